// File: doc/BRIEF.md
# Masked Complement Test Unit

This block executes one byte-wide bit-test operation for a small 8-bit register-file processor. Given an opcode and up to two operand bytes, it finds a destination byte and a mask byte through one of six addressing forms, using an internal 256-byte register file. It then forms the inverted destination ANDed with the mask. The result is not stored. It only drives the zero and sign status flags. The overflow flag is forced low and the remaining flags pass through unchanged. The destination register is never written, so software can test whether every masked bit of a register is 1 and leave that register intact.

The operation starts with a one-cycle `start` strobe. The opcode, the operand bytes, the working-register bank nibble and the current flag byte are all captured on that edge. `done` is high for exactly one cycle, which is the last cycle of the opcode's fixed length. `flags_out` takes its new value in that same cycle. An opcode outside the supported set raises `err` for one cycle and returns the incoming flags unchanged. A host port loads the register file and reads it back.

Top module: `masktest_unit`

## Requirements
- R1: The result is (NOT destination) AND mask. The zero flag, at flags bit 6, is 1 exactly when the result is 0x00.
- R2: The sign flag, at flags bit 5, equals result bit 7. The overflow flag, at flags bit 4, is always 0 after the operation.
- R3: Flags bits 7 (carry), 3 (decimal adjust), 2 (half carry), 1 and 0 keep the values that `flags_in` had on the start edge.
- R4: The destination register keeps its value. The operation performs no register-file write.
- R5: Opcodes 0x62 and 0x63 take destination and source working-register numbers from `byte_a` bits 7:4 and 3:0. 0x62 reads the source register directly. 0x63 uses its contents as the mask address. `done` is high in cycle 6 after the start edge.
- R6: Opcode 0x64 takes the source register from `byte_a` and the destination register from `byte_b`. Opcode 0x65 does the same, but the source register holds the mask's address. `done` is high in cycle 10.
- R7: Opcode 0x66 takes the destination register from `byte_a` and the mask directly from `byte_b`. Opcode 0x67 does the same, but the destination register holds the destination's address. `done` is high in cycle 10.
- R8: A working-register number n, and any register byte of the form 0xEn, addresses register {`rp_hi`, n}. `rp_hi` is captured on the start edge.
- R9: Any other opcode sets `err` for the one cycle after the start edge and loads `flags_out` with `flags_in`. It gives no `done`.
- R10: `done` lasts one cycle. `flags_out` changes only in a `done` cycle or an `err` cycle.
- R11: `start` is ignored while an operation is running, except in its `done` cycle, where a new operation is accepted back to back.
- R12: During and after reset, `flags_out` is 0x00 and `done`, `err` and `busy` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation |
| opcode | input | 8 | Opcode byte |
| byte_a | input | 8 | First operand byte |
| byte_b | input | 8 | Second operand byte |
| rp_hi | input | 4 | Working-register bank nibble |
| flags_in | input | 8 | Flag byte before the operation |
| flags_out | output | 8 | Flag byte after the latest operation |
| done | output | 1 | High in the final cycle of an operation |
| err | output | 1 | Unsupported opcode pulse |
| busy | output | 1 | Operation in progress |
| host_we | input | 1 | Register-file write strobe |
| host_waddr | input | 8 | Register-file write address |
| host_wdata | input | 8 | Register-file write data |
| host_raddr | input | 8 | Register-file read address |
| host_rdata | output | 8 | Register-file read data |

## Verification
The completion of one operation and the acceptance of the next can fall in the same cycle. That cycle carries `done` and the new flags, and a fresh `start` is sampled on the edge that closes it. The bench provokes this by driving `start` in the cycle where it observes `done`. The scoreboard then expects both the first operation's flags and cycle count and the second operation's full-length count measured from that edge. The bench also provokes an unsupported opcode started inside a `done` cycle in the same way, and judges it by the `err` pulse and the restored flags.

// File: rtl/masktest_pkg.sv
package masktest_pkg;

    localparam int FLAG_C = 7;
    localparam int FLAG_Z = 6;
    localparam int FLAG_S = 5;
    localparam int FLAG_V = 4;
    localparam int FLAG_D = 3;
    localparam int FLAG_H = 2;

    localparam logic [3:0] WREG_PREFIX = 4'hE;

    typedef enum logic [2:0] {
        M_WW     = 3'd0,  // working dst, working src
        M_WWI    = 3'd1,  // working dst, indirect working src
        M_RR     = 3'd2,  // register dst, register src
        M_RRI    = 3'd3,  // register dst, indirect register src
        M_RIMM   = 3'd4,  // register dst, immediate mask
        M_RIIMM  = 3'd5,  // indirect register dst, immediate mask
        M_BAD    = 3'd7
    } mode_e;

    function automatic mode_e decode_op(input logic [7:0] op);
        case (op)
            8'h62:   return M_WW;
            8'h63:   return M_WWI;
            8'h64:   return M_RR;
            8'h65:   return M_RRI;
            8'h66:   return M_RIMM;
            8'h67:   return M_RIIMM;
            default: return M_BAD;
        endcase
    endfunction

    function automatic logic is_short(input mode_e m);
        return (m == M_WW) || (m == M_WWI);
    endfunction

    function automatic logic [7:0] map_reg(input logic [7:0] a, input logic [3:0] rp);
        return (a[7:4] == WREG_PREFIX) ? {rp, a[3:0]} : a;
    endfunction

endpackage

// File: rtl/masktest_rf.sv
module masktest_rf #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] dst1_addr,
    output logic [DW-1:0] dst1_data,
    input  logic [AW-1:0] src1_addr,
    output logic [DW-1:0] src1_data,
    input  logic [AW-1:0] dst2_addr,
    output logic [DW-1:0] dst2_data,
    input  logic [AW-1:0] src2_addr,
    output logic [DW-1:0] src2_data,
    input  logic [AW-1:0] host_addr,
    output logic [DW-1:0] host_data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign dst1_data = mem_q[dst1_addr];
    assign src1_data = mem_q[src1_addr];
    assign dst2_data = mem_q[dst2_addr];
    assign src2_data = mem_q[src2_addr];
    assign host_data = mem_q[host_addr];

endmodule

// File: rtl/masktest_resolve.sv
module masktest_resolve
    import masktest_pkg::*;
(
    input  mode_e       mode,
    input  logic [7:0]  byte_a,
    input  logic [7:0]  byte_b,
    input  logic [3:0]  rp,
    output logic [7:0]  dst1_addr,
    output logic [7:0]  src1_addr,
    input  logic [7:0]  dst1_data,
    input  logic [7:0]  src1_data,
    input  logic [7:0]  dst2_data,
    input  logic [7:0]  src2_data,
    output logic [7:0]  dst_val,
    output logic [7:0]  src_val,
    output logic [7:0]  dst_final_addr
);
    logic ind_dst;
    logic ind_src;
    logic use_imm;

    always_comb begin
        dst1_addr = map_reg(byte_a, rp);
        src1_addr = map_reg(byte_b, rp);
        ind_dst   = 1'b0;
        ind_src   = 1'b0;
        use_imm   = 1'b0;
        case (mode)
            M_WW, M_WWI: begin
                dst1_addr = {rp, byte_a[7:4]};
                src1_addr = {rp, byte_a[3:0]};
                ind_src   = (mode == M_WWI);
            end
            M_RR, M_RRI: begin
                src1_addr = map_reg(byte_a, rp);
                dst1_addr = map_reg(byte_b, rp);
                ind_src   = (mode == M_RRI);
            end
            M_RIMM, M_RIIMM: begin
                dst1_addr = map_reg(byte_a, rp);
                use_imm   = 1'b1;
                ind_dst   = (mode == M_RIIMM);
            end
            default: begin
            end
        endcase

        dst_val        = ind_dst ? dst2_data : dst1_data;
        dst_final_addr = ind_dst ? dst1_data : dst1_addr;
        if (use_imm) begin
            src_val = byte_b;
        end else if (ind_src) begin
            src_val = src2_data;
        end else begin
            src_val = src1_data;
        end
    end

endmodule

// File: rtl/masktest_flagcalc.sv
module masktest_flagcalc
    import masktest_pkg::*;
(
    input  logic [7:0] dst_val,
    input  logic [7:0] mask_val,
    input  logic [7:0] flags_prev,
    output logic [7:0] flags_new
);
    logic [7:0] result;

    always_comb begin
        result            = ~dst_val & mask_val;
        flags_new         = flags_prev;
        flags_new[FLAG_Z] = (result == 8'h00);
        flags_new[FLAG_S] = result[7];
        flags_new[FLAG_V] = 1'b0;
    end

endmodule

// File: rtl/masktest_unit.sv
module masktest_unit
    import masktest_pkg::*;
#(
    parameter int SHORT_CYC = 6,
    parameter int LONG_CYC  = 10
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] opcode,
    input  logic [7:0] byte_a,
    input  logic [7:0] byte_b,
    input  logic [3:0] rp_hi,
    input  logic [7:0] flags_in,
    output logic [7:0] flags_out,
    output logic       done,
    output logic       err,
    output logic       busy,
    input  logic       host_we,
    input  logic [7:0] host_waddr,
    input  logic [7:0] host_wdata,
    input  logic [7:0] host_raddr,
    output logic [7:0] host_rdata
);
    localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        mode_e         mode;
        logic [7:0]    a;
        logic [7:0]    b;
        logic [3:0]    rp;
        logic [7:0]    cap;
        logic [7:0]    flags;
        logic          err;
    } state_t;

    state_t st_q, st_d;

    logic [7:0] dst1_addr, src1_addr, dst1_data, src1_data, dst2_data, src2_data;
    logic [7:0] dst_val, src_val, dst_final_addr, flags_new;
    mode_e      dec_mode;
    logic       accept;

    masktest_rf #(.AW(8), .DW(8)) rf_i (
        .clk       (clk),
        .we        (host_we),
        .waddr     (host_waddr),
        .wdata     (host_wdata),
        .dst1_addr (dst1_addr),
        .dst1_data (dst1_data),
        .src1_addr (src1_addr),
        .src1_data (src1_data),
        .dst2_addr (dst1_data),
        .dst2_data (dst2_data),
        .src2_addr (src1_data),
        .src2_data (src2_data),
        .host_addr (host_raddr),
        .host_data (host_rdata)
    );

    masktest_resolve res_i (
        .mode           (st_q.mode),
        .byte_a         (st_q.a),
        .byte_b         (st_q.b),
        .rp             (st_q.rp),
        .dst1_addr      (dst1_addr),
        .src1_addr      (src1_addr),
        .dst1_data      (dst1_data),
        .src1_data      (src1_data),
        .dst2_data      (dst2_data),
        .src2_data      (src2_data),
        .dst_val        (dst_val),
        .src_val        (src_val),
        .dst_final_addr (dst_final_addr)
    );

    masktest_flagcalc fc_i (
        .dst_val    (dst_val),
        .mask_val   (src_val),
        .flags_prev (st_q.cap),
        .flags_new  (flags_new)
    );

    always_comb begin
        st_d     = st_q;
        st_d.err = 1'b0;
        dec_mode = decode_op(opcode);
        accept   = start && (st_q.cnt <= CW'(1));

        if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
        end
        // flags land on the edge that opens the final cycle
        if (st_q.cnt == CW'(2)) begin
            st_d.flags = flags_new;
        end

        if (accept) begin
            if (dec_mode == M_BAD) begin
                st_d.err   = 1'b1;
                st_d.flags = flags_in;
            end else begin
                st_d.mode = dec_mode;
                st_d.a    = byte_a;
                st_d.b    = byte_b;
                st_d.rp   = rp_hi;
                st_d.cap  = flags_in;
                st_d.cnt  = is_short(dec_mode) ? CW'(SHORT_CYC) : CW'(LONG_CYC);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, mode: M_WW, a: '0, b: '0, rp: '0,
                      cap: '0, flags: '0, err: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_out = st_q.flags;
    assign done      = (st_q.cnt == CW'(1));
    assign err       = st_q.err;
    assign busy      = (st_q.cnt != '0);

    // R10: completion strobe never stretches
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2: overflow flag is low whenever a result is presented
    p_v_clear_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !flags_out[FLAG_V]);

    // R1 and R2: a set sign bit means a nonzero result
    p_sign_nonzero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && flags_out[FLAG_S]) |-> !flags_out[FLAG_Z]);

    // R9: rejected opcode hands back the incoming flags
    p_err_restore_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (flags_out == $past(flags_in)));

    // R10: flags hold outside completion and error cycles
    p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!done && !err) |-> $stable(flags_out));

    // R11: a start in a busy non-final cycle does not restart the count
    p_busy_ignore_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !done) |=> (st_q.cnt == $past(st_q.cnt) - CW'(1)));

    // R4: the operation has no path into the register file
    p_no_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !host_we) |=> (host_rdata == $past(host_rdata)) || (host_raddr != $past(host_raddr)));

endmodule

// File: tb/masktest_unit_tb_top.sv
`timescale 1ns/1ps
module masktest_unit_tb_top;

    typedef struct {
        logic [7:0] flags;
        int         done_cyc;
        logic [7:0] dst_addr;
        logic [7:0] dst_val;
        string      req;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic [7:0] opcode = '0, byte_a = '0, byte_b = '0, flags_in = '0;
    logic [3:0] rp_hi = '0;
    logic       host_we = 1'b0;
    logic [7:0] host_waddr = '0, host_wdata = '0, host_raddr = '0;
    logic [7:0] flags_out, host_rdata;
    logic       done, err, busy;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] mirror [256];
    item_t      q[$];
    logic [7:0] last_flags = '0;

    always #2.5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    masktest_unit dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode),
        .byte_a(byte_a), .byte_b(byte_b), .rp_hi(rp_hi), .flags_in(flags_in),
        .flags_out(flags_out), .done(done), .err(err), .busy(busy),
        .host_we(host_we), .host_waddr(host_waddr), .host_wdata(host_wdata),
        .host_raddr(host_raddr), .host_rdata(host_rdata)
    );

    task automatic check(input logic ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] wmap(input logic [7:0] a);
        return (a[7:4] == 4'hE) ? {rp_hi, a[3:0]} : a;
    endfunction

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        host_we = 1'b1; host_waddr = a; host_wdata = d;
        mirror[a] = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    // called at a falling edge; start is sampled on the next rising edge
    task automatic issue(input logic [7:0] op, input logic [7:0] a, input logic [7:0] b,
                         input logic [7:0] fin, input string req);
        item_t it;
        logic [7:0] da, dv, sv, res;
        int n;
        case (op)
            8'h62, 8'h63: begin
                da = {rp_hi, a[7:4]};
                sv = mirror[{rp_hi, a[3:0]}];
                if (op == 8'h63) sv = mirror[sv];
            end
            8'h64, 8'h65: begin
                da = wmap(b);
                sv = mirror[wmap(a)];
                if (op == 8'h65) sv = mirror[sv];
            end
            default: begin
                da = wmap(a);
                if (op == 8'h67) da = mirror[da];
                sv = b;
            end
        endcase
        dv  = mirror[da];
        res = ~dv & sv;
        n   = (op == 8'h62 || op == 8'h63) ? 6 : 10;
        it.flags    = {fin[7], (res == 8'h00), res[7], 1'b0, fin[3:0]};
        it.done_cyc = cyc + n;
        it.dst_addr = da;
        it.dst_val  = dv;
        it.req      = req;
        q.push_back(it);
        opcode = op; byte_a = a; byte_b = b; flags_in = fin; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        flags_in = ~fin;  // later changes must not matter (R3)
    endtask

    task automatic wait_done();
        do @(negedge clk); while (!done);
    endtask

    task automatic wait_idle();
        while (q.size() != 0) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    // monitor / scoreboard
    always @(negedge clk) begin
        if (rst_n) begin
            if (!done && !err)
                check(flags_out == last_flags, "R10", "flags moved outside done/err",
                      flags_out, last_flags);
            last_flags = flags_out;
            if (done) begin
                if (q.size() == 0) begin
                    check(1'b0, "R11", "unexpected done", 1, 0);
                end else begin
                    item_t it;
                    it = q.pop_front();
                    check(flags_out == it.flags, {it.req, " R1/R2/R3"}, "flags",
                          flags_out, it.flags);
                    check(cyc == it.done_cyc, it.req, "done cycle", cyc, it.done_cyc);
                    host_raddr = it.dst_addr;
                    #1;
                    check(host_rdata == it.dst_val, "R4", "destination changed",
                          host_rdata, it.dst_val);
                end
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog", "run did not finish", 0, 1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) mirror[i] = 8'h00;
        repeat (3) @(negedge clk);
        // R12: reset values
        check(flags_out == 8'h00 && !done && !err && !busy, "R12", "reset state",
              {flags_out, 1'b0, done, err, busy}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        for (int i = 0; i < 256; i++) wr(i[7:0], 8'h00);

        rp_hi = 4'h3;
        // R5: working/working, example values, all preserved flags set
        wr(8'h31, 8'hF6); wr(8'h32, 8'h06);
        issue(8'h62, 8'h12, 8'h00, 8'hFF, "R5");
        wait_idle();
        // R5: indirect working source
        wr(8'h34, 8'h0F); wr(8'h35, 8'h80); wr(8'h80, 8'hF3);
        issue(8'h63, 8'h45, 8'h00, 8'h10, "R5");
        wait_idle();
        // R6 and R8: register/register with working-prefix source
        wr(8'h37, 8'h3C); wr(8'h90, 8'hC3);
        issue(8'h64, 8'hE7, 8'h90, 8'h8C, "R6 R8");
        wait_idle();
        // R6 and R8: indirect source, working-prefix destination
        wr(8'h50, 8'hA0); wr(8'hA0, 8'h81); wr(8'h39, 8'h7E);
        issue(8'h65, 8'h50, 8'hE9, 8'h04, "R6 R8");
        wait_idle();
        // R7: immediate mask, sign result
        wr(8'h70, 8'h00);
        issue(8'h66, 8'h70, 8'h80, 8'h5B, "R7");
        wait_idle();
        // R7 and R8: indirect destination through working register
        wr(8'h3A, 8'h71); wr(8'h71, 8'h5A);
        issue(8'h67, 8'hEA, 8'hFF, 8'hA7, "R7 R8");
        wait_idle();

        // R9: rejected opcode
        opcode = 8'h61; flags_in = 8'hA5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(err == 1'b1, "R9", "err pulse", err, 1);
        check(flags_out == 8'hA5, "R9", "flags restored", flags_out, 8'hA5);
        check(busy == 1'b0, "R9", "no operation started", busy, 0);
        @(negedge clk);
        check(err == 1'b0, "R9", "err single cycle", err, 0);
        repeat (12) @(negedge clk);

        // R11: start while busy is ignored
        rp_hi = 4'hC;
        wr(8'hC1, 8'h55); wr(8'hC2, 8'hAA);
        issue(8'h62, 8'h12, 8'h00, 8'h00, "R5 R11");
        @(negedge clk);
        opcode = 8'h66; byte_a = 8'hC1; byte_b = 8'hFF; flags_in = 8'hFF; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(err == 1'b0, "R11", "no reaction to busy start", err, 0);
        wait_idle();

        // R11: back-to-back acceptance in the done cycle
        wr(8'hC5, 8'h0F); wr(8'hC6, 8'hF0);
        issue(8'h62, 8'h56, 8'h00, 8'h0C, "R5 R11");
        wait_done();
        issue(8'h66, 8'hC5, 8'hF0, 8'h83, "R7 R11");
        wait_done();
        // rejected opcode accepted inside a done cycle
        opcode = 8'h00; flags_in = 8'h3C; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(err == 1'b1 && flags_out == 8'h3C, "R9", "err after done cycle",
              flags_out, 8'h3C);
        wait_idle();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule